// File: doc/BRIEF.md
# Second-Order Wave Digital Allpass Section (Three-Port Parallel Adaptor)

This block is a second-order allpass filter built as a wave digital structure. It uses a single three-port parallel adaptor whose two free ports close through one unit delay each. One port closes through a plain delay. The other closes through a delay with a sign inversion. The remaining port carries the input sample, and the reflected wave at that port gives the output. The two adaptor coefficients are fixed when the block is elaborated. Each multiply by a coefficient is a tree of shifts and adds/subtracts, built from the canonical signed-digit form of the coefficient code, so the block contains no general multiplier.

A caller presents one signed sample together with a valid strobe. One clock later the block returns exactly one filtered sample. Cycles without a valid strobe leave the filter untouched. Internal sums carry guard bits so that the recursion never wraps. Only the final output is clamped to the sample width. Two of these sections, possibly with first-order sections as well, make up one branch of a lattice wave digital filter.

The magnitude response is flat. The phase follows H(z) = (c + d·z^-1 − z^-2) / (−1 + d·z^-1 + c·z^-2), where c = 1 − β1 − β2 and d = β1 − β2. These coefficients map from an equivalent pair of first-order gammas as β1 = (1 − γ1)(1 + γ2)/2 and β2 = (γ1 − 1)(γ2 − 1)/2.

Top module: `wdf3_allpass`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` becomes 0, `out_sample` becomes 0 and both delay states clear. After reset is released, the block behaves exactly as a freshly started filter.
- R2: `out_valid` is 1 in the cycle right after a rising edge where `in_valid` was 1, and is 0 otherwise. There is one output per accepted input, with a latency of one clock.
- R3: A rising edge with `in_valid` low changes neither `out_sample` nor either delay state. Later outputs are the same as if the idle cycle had never occurred.
- R4: For an accepted sample x, with states s1 and s2, the block computes p = s1 − x and q = −s2 − x. It then computes m1 = floor(p·B1_Q / 2^FRAC), m2 = floor(q·B2_Q / 2^FRAC) and a0 = 2x + m1 + m2. The output is y = x − a0, after the clamp of R7. The states update as s1 ← a0 − s1 and s2 ← a0 + s2.
- R5: Each coefficient is an unsigned integer code with FRAC fractional bits, in the range 0 ≤ code < 2^(FRAC+1), so a β between 1 and 2 is represented exactly. The shift-add network gives the exact product code·operand before the floor step.
- R6: Starting from cleared states, the first output for an impulse of amplitude A is (β1 + β2 − 1)·A to within 2 LSB.
- R7: The output is clamped to the range [−2^(DW−1), 2^(DW−1) − 1] and never wraps.
- R8: With any input sequence, including a full-scale input, a0 and both next states stay within the signed GUARD+DW-bit internal range.
- R9: Over a long random input sequence, the output energy is within ±10 % of the input energy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` for the current edge |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Marks a new filtered sample |
| out_sample | output | DW | Signed filtered sample, clamped |

## Verification
The bench builds the block with DW=8, GUARD=6, FRAC=9, B1_Q=689 (about 1.346) and B2_Q=77 (about 0.150). With this coefficient pair, β1 is above 1, so the integer bit of the coefficient and the subtract digits of its signed-digit form are exercised. The poles sit close enough to the unit circle that the internal states grow well beyond the input. An input pattern matched to the section's own impulse response drives the output into the clamp. That same full-scale run pushes the guard bits as hard as the recursion permits.

// File: rtl/wdf3_pkg.sv
package wdf3_pkg;

    // Canonical signed-digit expansion of a non-negative integer:
    // returns the digit (-1, 0 or +1) at weight 2^pos.
    function automatic int csd_digit(input int value, input int pos);
        int n;
        int d;
        n = value;
        d = 0;
        for (int i = 0; i <= pos; i++) begin
            if ((n & 1) != 0) begin
                d = ((n & 3) == 1) ? 1 : -1;
                n = (n - d) >>> 1;
            end else begin
                d = 0;
                n = n >>> 1;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/wdf3_csd_mult.sv
module wdf3_csd_mult #(
    parameter int IN_W = 15,
    parameter int FRAC = 9,
    parameter int COEF = 689,
    localparam int NDIG  = FRAC + 3,
    localparam int OUT_W = IN_W + NDIG
) (
    input  logic signed [IN_W-1:0]  op_i,
    output logic signed [OUT_W-1:0] prod_o
);

    logic signed [OUT_W-1:0] op_ext;
    logic signed [OUT_W-1:0] acc [NDIG+1];

    assign op_ext = OUT_W'(op_i);
    assign acc[0] = '0;

    // One adder, subtractor or feed-through per signed digit of COEF
    for (genvar k = 0; k < NDIG; k++) begin : g_digit
        localparam int DG = wdf3_pkg::csd_digit(COEF, k);
        if (DG == 1) begin : g_add
            assign acc[k+1] = acc[k] + (op_ext <<< k);
        end else if (DG == -1) begin : g_sub
            assign acc[k+1] = acc[k] - (op_ext <<< k);
        end else begin : g_pass
            assign acc[k+1] = acc[k];
        end
    end

    assign prod_o = acc[NDIG];

endmodule

// File: rtl/wdf3_sat.sv
module wdf3_sat #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] val_o
);

    localparam logic signed [IN_W-1:0] HI = IN_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [IN_W-1:0] LO = -HI - IN_W'(1);

    always_comb begin
        if (val_i > HI) begin
            val_o = OUT_W'(HI);
        end else if (val_i < LO) begin
            val_o = OUT_W'(LO);
        end else begin
            val_o = val_i[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/wdf3_allpass.sv
module wdf3_allpass #(
    parameter int DW    = 8,
    parameter int GUARD = 6,
    parameter int FRAC  = 9,
    parameter int B1_Q  = 689,
    parameter int B2_Q  = 77
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);

    localparam int IW = DW + GUARD;        // loop state width
    localparam int PW = IW + 1;            // adaptor port difference width
    localparam int MW = PW + FRAC + 3;     // raw product width
    localparam int AW = IW + 2;            // summation width

    localparam logic signed [AW-1:0] LIM_HI = AW'((64'sd1 <<< (IW - 1)) - 64'sd1);
    localparam logic signed [AW-1:0] LIM_LO = -LIM_HI - AW'(1);

    typedef struct packed {
        logic signed [IW-1:0] s1;
        logic signed [IW-1:0] s2;
        logic signed [DW-1:0] y;
        logic                 vld;
    } st_t;

    st_t st_d, st_q;

    logic signed [IW-1:0] x_ext;
    logic signed [PW-1:0] diff1, diff2;
    logic signed [MW-1:0] prod1, prod2;
    logic signed [AW-1:0] m1_w, m2_w, a0_w, s1_w, s2_w, y_w;
    logic signed [DW-1:0] y_sat;

    assign x_ext = IW'(in_sample);
    // port 2 closes through a plain delay, port 3 through an inverting delay
    assign diff1 = PW'(st_q.s1) - PW'(x_ext);
    assign diff2 = -PW'(st_q.s2) - PW'(x_ext);

    wdf3_csd_mult #(.IN_W(PW), .FRAC(FRAC), .COEF(B1_Q)) u_mul1 (
        .op_i   (diff1),
        .prod_o (prod1)
    );

    wdf3_csd_mult #(.IN_W(PW), .FRAC(FRAC), .COEF(B2_Q)) u_mul2 (
        .op_i   (diff2),
        .prod_o (prod2)
    );

    assign m1_w = AW'(prod1 >>> FRAC);
    assign m2_w = AW'(prod2 >>> FRAC);
    assign a0_w = (AW'(x_ext) <<< 1) + m1_w + m2_w;
    assign s1_w = a0_w - AW'(st_q.s1);
    assign s2_w = a0_w + AW'(st_q.s2);
    assign y_w  = AW'(x_ext) - a0_w;

    wdf3_sat #(.IN_W(AW), .OUT_W(DW)) u_sat (
        .val_i (y_w),
        .val_o (y_sat)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.s1 = IW'(s1_w);
            st_d.s2 = IW'(s2_w);
            st_d.y  = y_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_sample = st_q.y;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    // R8
    loop_range_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (a0_w <= LIM_HI && a0_w >= LIM_LO &&
                      s1_w <= LIM_HI && s1_w >= LIM_LO &&
                      s2_w <= LIM_HI && s2_w >= LIM_LO));

endmodule

// File: tb/wdf3_allpass_tb.sv
module wdf3_allpass_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 8;
    localparam int GUARD = 6;
    localparam int FRAC  = 9;
    localparam int B1_Q  = 689;
    localparam int B2_Q  = 77;
    localparam longint YMAX = (longint'(1) <<< (DW - 1)) - 1;
    localparam longint YMIN = -YMAX - 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_sample;

    wdf3_allpass #(.DW(DW), .GUARD(GUARD), .FRAC(FRAC), .B1_Q(B1_Q), .B2_Q(B2_Q)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    longint rs1 = 0;
    longint rs2 = 0;
    longint exp_q[$];
    int     req_q[$];
    int     clamp_hits = 0;
    longint e_in = 0;
    longint e_out = 0;
    logic   lat_in = 1'b0;
    logic   lat_rst = 1'b1;
    longint last_y = 0;

    task automatic check(input bit ok, input int req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Reference model written from the recursion in R4 with plain multiplies
    task automatic ref_step(input longint x, inout longint s1, inout longint s2,
                            output longint y, output bit clip);
        longint p, q, m1, m2, a0, yw;
        p  = s1 - x;
        q  = -s2 - x;
        m1 = (p * B1_Q) >>> FRAC;
        m2 = (q * B2_Q) >>> FRAC;
        a0 = 2 * x + m1 + m2;
        yw = x - a0;
        s1 = a0 - s1;
        s2 = a0 + s2;
        clip = 1'b0;
        y = yw;
        if (yw > YMAX) begin y = YMAX; clip = 1'b1; end
        if (yw < YMIN) begin y = YMIN; clip = 1'b1; end
    endtask

    task automatic send(input longint x, input int req);
        longint y;
        bit     clip;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = DW'(x);
        ref_step(x, rs1, rs2, y, clip);
        if (clip) clamp_hits++;
        if (req == 9) e_in += x * x;
        exp_q.push_back(y);
        req_q.push_back(req);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R1: outputs cleared while reset is applied
        check(out_valid == 1'b0, 1, longint'(out_valid), 0);
        check(out_sample == '0, 1, longint'(out_sample), 0);
        rs1 = 0;
        rs2 = 0;
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        lat_in  <= in_valid;
        lat_rst <= rst;
    end

    // Monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (lat_rst) begin
            last_y = 0;
        end else begin
            // R2: one output exactly one clock after each accepted sample
            check(out_valid == lat_in, 2, longint'(out_valid), longint'(lat_in));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, 2, longint'(out_sample), 0);
                end else begin
                    automatic longint ev = exp_q.pop_front();
                    automatic int     rq = req_q.pop_front();
                    check(longint'(out_sample) == ev, rq, longint'(out_sample), ev);
                    if (rq == 9) e_out += longint'(out_sample) * longint'(out_sample);
                end
                last_y = longint'(out_sample);
            end else begin
                // R3: output held across idle cycles
                check(longint'(out_sample) == last_y, 3, longint'(out_sample), last_y);
            end
        end
    end

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint hs1, hs2, hy;
        bit     hc;
        bit     hsign [16];

        repeat (3) @(negedge clk);
        // R1: reset state at start
        check(out_valid == 1'b0, 1, longint'(out_valid), 0);
        check(out_sample == '0, 1, longint'(out_sample), 0);
        rst = 1'b0;
        idle(2);

        // R6: leading impulse term ~ (b1+b2-1)*64 = 31.75
        send(64, 6);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_sample >= 30 && out_sample <= 34, 6, longint'(out_sample), 32);
        idle(20);

        // R5: step run where beta1 > 1 and its subtract digits matter
        for (int i = 0; i < 40; i++) send(50, 5);
        idle(3);

        // R4 and R3: random samples with random idle gaps
        for (int i = 0; i < 300; i++) begin
            send(longint'($urandom_range(200)) - 100, 4);
            if ($urandom_range(3) == 0) idle(int'($urandom_range(3)) + 1);
        end
        idle(4);

        // R1: a reset mid-stream restarts the filter from cleared states
        do_reset();
        idle(1);
        send(-64, 1);
        for (int i = 0; i < 10; i++) send(0, 1);
        idle(3);

        // R7 and R8: full-scale input matched to the impulse response
        do_reset();
        hs1 = 0;
        hs2 = 0;
        for (int k = 0; k < 16; k++) begin
            ref_step((k == 0) ? 100 : 0, hs1, hs2, hy, hc);
            hsign[k] = (hy >= 0);
        end
        clamp_hits = 0;
        for (int n = 0; n < 16; n++) send(hsign[15 - n] ? 127 : -128, 8);
        for (int n = 0; n < 16; n++) send(hsign[15 - n] ? -128 : 127, 8);
        for (int n = 0; n < 30; n++) send(0, 7);
        idle(3);
        // R7: the matched pattern must reach the clamp
        check(clamp_hits > 0, 7, clamp_hits, 1);

        // R9: energy preserved for a long random sequence
        do_reset();
        e_in = 0;
        e_out = 0;
        for (int i = 0; i < 4000; i++) send(longint'($urandom_range(96)) - 48, 9);
        idle(4);
        check(10 * e_out >= 9 * e_in && 10 * e_out <= 11 * e_in, 9, e_out, e_in);

        // R2: every accepted sample produced its output
        check(exp_q.size() == 0, 2, exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule